// File: doc/BRIEF.md
# Masked-Access Eight-Pin GPIO Port

This block is one general-purpose I/O port of eight pins, controlled through a small memory-mapped register file on a simple word bus (address, write data, write strobe, read strobe, read data). Software sets each pin's direction, whether an alternate function owns it, whether its digital path is enabled, and which weak pull is engaged. It then moves data through the data window.

The data window spans offsets 0x000 to 0x3FC. Address bits 9:2 of a data access form a per-pin mask: a write updates only the selected pins, and a read returns zero for pins that are not selected. The two pull registers are arbitrated against each other. Setting a bit in one clears the same bit in the other, so the pull written last wins. Pin inputs pass through a two-flop synchronizer before they can be read.

Top module: `gpio8_mask_port`

## Requirements
- R1: After reset, every register reads 0 and `pin_oe`, `pin_out`, `pin_pu` and `pin_pd` are all 0.
- R2: A write to an address whose bits 11:10 are 00 changes the output latch bit of pin i only if address bit 2+i is 1. The latch is visible on `pin_out` after the clock edge.
- R3: A data-window read returns 0 for pin i when address bit 2+i is 0. Offset 0x3FC selects all eight pins.
- R4: The direction register is at offset 0x400, with 1 meaning output. `pin_oe[i]` is 1 only when direction, digital enable and plain-GPIO function all hold for pin i.
- R5: The alternate-select register is at offset 0x420. A 1 in bit i removes pin i from GPIO drive, so `pin_oe[i]` is 0.
- R6: The digital-enable register is at offset 0x51C. A pin whose bit is 0 never drives and reads 0 in the data window.
- R7: The pull-up register is at offset 0x510. A write to it loads the value and clears the matching bits of the pull-down register.
- R8: The pull-down register is at offset 0x514. A write to it loads the value and clears the matching bits of the pull-up register.
- R9: Read-data bits 31:8 are always 0, and write-data bits 31:8 are ignored.
- R10: For an enabled pin, a data read returns the output latch when the direction bit is 1. Otherwise it returns the pin level, delayed by two clock edges through the synchronizer.
- R11: Offsets outside the data window and the five register offsets read 0, and writes to them change nothing.
- R12: When read and write strobes are both active on the same address in one cycle, the read returns the value held before the write. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational while `bus_re` is high, else 0 |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Pull-up enables |
| pin_pd | output | 8 | Pull-down enables |

## Verification
Two functions can fall in the same cycle: a register write and a read of that same register, and a pin-level change and a data-window read of that pin. The bench raises both strobes together on the direction register. It expects the old value before the edge and the new value one cycle later. It also changes `pin_in` just before a read and expects the old level until two clock edges have passed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_PINS   = 8;
  localparam int BUS_ADDR_W  = 12;
  localparam int BUS_DATA_W  = 32;
  localparam logic [BUS_ADDR_W-1:0] OFS_DIR  = 12'h400;
  localparam logic [BUS_ADDR_W-1:0] OFS_ALT  = 12'h420;
  localparam logic [BUS_ADDR_W-1:0] OFS_PUP  = 12'h510;
  localparam logic [BUS_ADDR_W-1:0] OFS_PDN  = 12'h514;
  localparam logic [BUS_ADDR_W-1:0] OFS_DEN  = 12'h51C;

  typedef struct packed {
    logic data;
    logic dir;
    logic alt;
    logic den;
    logic pup;
    logic pdn;
  } reg_sel_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_pull_arb.sv
module gpio_pull_arb #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_up,
  input  logic         wr_dn,
  input  logic [W-1:0] wval,
  output logic [W-1:0] up_q,
  output logic [W-1:0] dn_q
);
  logic [W-1:0] up_d, dn_d;
  logic         up_en, dn_en;

  always_comb begin
    up_d  = up_q;
    dn_d  = dn_q;
    up_en = 1'b0;
    dn_en = 1'b0;
    if (wr_up) begin
      up_d  = wval;
      dn_d  = dn_q & ~wval;
      up_en = 1'b1;
      dn_en = 1'b1;
    end else if (wr_dn) begin
      dn_d  = wval;
      up_d  = up_q & ~wval;
      up_en = 1'b1;
      dn_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      if (up_en) up_q <= up_d;
      if (dn_en) dn_q <= dn_d;
    end
  end

  // R7: a pull-up write leaves no pull-down bit where the written value had a 1
  assert_pup_clears_pdn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_up |=> ((dn_q & $past(wval)) == '0));
  // R8: a pull-down write leaves no pull-up bit where the written value had a 1
  assert_pdn_clears_pup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dn && !wr_up) |=> ((up_q & $past(wval)) == '0));
  // R7: the two pulls never overlap on a pin
  assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q & dn_q) == '0);
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic         wr_dir,
  input  logic         wr_alt,
  input  logic         wr_den,
  input  logic [W-1:0] wval,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] alt_q,
  output logic [W-1:0] den_q
);
  logic [W-1:0] data_d;

  always_comb begin
    data_d = (data_q & ~wr_mask) | (wval & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
      den_q  <= '0;
    end else begin
      if (wr_data) data_q <= data_d;
      if (wr_dir)  dir_q  <= wval;
      if (wr_alt)  alt_q  <= wval;
      if (wr_den)  den_q  <= wval;
    end
  end

  // R2: pins outside the write mask keep their latch value
  assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (((data_q ^ $past(data_q)) & ~$past(wr_mask)) == '0));
  // R11: without a data write the latch does not move
  assert_latch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(data_q));
endmodule

// File: rtl/gpio8_mask_port.sv
module gpio8_mask_port
  import gpio_pkg::*;
#(
  parameter int PINS   = PORT_PINS,
  parameter int ADDR_W = BUS_ADDR_W,
  parameter int DATA_W = BUS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_pu,
  output logic [PINS-1:0]   pin_pd
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PINS - 1;
  localparam int WIN_LSB = 10;
  localparam int PAD_W   = DATA_W - PINS;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic srst_n;
  assign srst_n = rst_s2_q;

  // decode
  reg_sel_t         sel;
  logic [PINS-1:0]  acc_mask;
  logic [PINS-1:0]  wval;

  always_comb begin
    sel.data = (bus_addr[ADDR_W-1:WIN_LSB] == '0);
    sel.dir  = (bus_addr[ADDR_W-1:2] == OFS_DIR[ADDR_W-1:2]);
    sel.alt  = (bus_addr[ADDR_W-1:2] == OFS_ALT[ADDR_W-1:2]);
    sel.den  = (bus_addr[ADDR_W-1:2] == OFS_DEN[ADDR_W-1:2]);
    sel.pup  = (bus_addr[ADDR_W-1:2] == OFS_PUP[ADDR_W-1:2]);
    sel.pdn  = (bus_addr[ADDR_W-1:2] == OFS_PDN[ADDR_W-1:2]);
  end

  assign acc_mask = bus_addr[MASK_HI:MASK_LO];
  assign wval     = bus_wdata[PINS-1:0];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PINS]};

  logic [PINS-1:0] data_q, dir_q, alt_q, den_q, pu_q, pd_q, in_sync;

  gpio_cfg_regs #(.W(PINS)) u_cfg (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_data (bus_we & sel.data),
    .wr_mask (acc_mask),
    .wr_dir  (bus_we & sel.dir),
    .wr_alt  (bus_we & sel.alt),
    .wr_den  (bus_we & sel.den),
    .wval    (wval),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .alt_q   (alt_q),
    .den_q   (den_q)
  );

  gpio_pull_arb #(.W(PINS)) u_pull (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_up (bus_we & sel.pup),
    .wr_dn (bus_we & sel.pdn),
    .wval  (wval),
    .up_q  (pu_q),
    .dn_q  (pd_q)
  );

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (srst_n),
    .d_in   (pin_in),
    .d_sync (in_sync)
  );

  // per-pin data-window read value
  logic [PINS-1:0] win_val;
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      if (!den_q[i] || !acc_mask[i]) win_val[i] = 1'b0;
      else if (dir_q[i])             win_val[i] = data_q[i];
      else                           win_val[i] = in_sync[i];
    end
  end

  logic [PINS-1:0] rd_low;
  always_comb begin
    rd_low = '0;
    unique case (1'b1)
      sel.data: rd_low = win_val;
      sel.dir:  rd_low = dir_q;
      sel.alt:  rd_low = alt_q;
      sel.den:  rd_low = den_q;
      sel.pup:  rd_low = pu_q;
      sel.pdn:  rd_low = pd_q;
      default:  rd_low = '0;
    endcase
  end

  assign bus_rdata = bus_re ? {{PAD_W{1'b0}}, rd_low} : '0;
  assign pin_out   = data_q;
  assign pin_oe    = dir_q & den_q & ~alt_q;
  assign pin_pu    = pu_q;
  assign pin_pd    = pd_q;

  // R9: upper read bits always zero
  assert_rdata_upper_zero_R9: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rdata[DATA_W-1:PINS] == '0);
  // R6: disabled pins read zero through the data window
  assert_den_read_zero_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_re && sel.data) |-> ((bus_rdata[PINS-1:0] & ~den_q) == '0));
  // R3: unmasked pins read zero
  assert_read_mask_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_re && sel.data) |-> ((bus_rdata[PINS-1:0] & ~acc_mask) == '0));
  // R4, R5: a driving pin is an output, digitally enabled and not handed to an alternate function
  assert_oe_gated_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ((pin_oe & ~(dir_q & den_q)) == '0) && ((pin_oe & alt_q) == '0));
endmodule

// File: tb/gpio8_mask_port_tb.sv
module gpio8_mask_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, pin_pu, pin_pd;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio8_mask_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  // vector: [45:44] op (1 write, 2 read-compare), [43:32] address, [31:0] data or expected
  localparam int NV = 23;
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 12'h51C, 32'hFFFF_FFFF},  // den all (R6)
    {2'd2, 12'h51C, 32'h0000_00FF},  // upper bits dropped (R9)
    {2'd1, 12'h400, 32'h0000_000F},  // low nibble output (R4)
    {2'd1, 12'h3FC, 32'h0000_00FF},  // full-mask write (R2)
    {2'd2, 12'h3FC, 32'h0000_00AF},  // outputs latch, inputs pins (R10)
    {2'd1, 12'h00C, 32'h0000_0000},  // masked clear pins 0,1 (R2)
    {2'd2, 12'h3FC, 32'h0000_00AC},  // R2
    {2'd2, 12'h030, 32'h0000_000C},  // mask pins 2,3 (R3)
    {2'd2, 12'h3C0, 32'h0000_00A0},  // mask high nibble (R3)
    {2'd1, 12'h510, 32'h0000_00F0},  // pull-up (R7)
    {2'd1, 12'h514, 32'h0000_0030},  // pull-down (R8)
    {2'd2, 12'h510, 32'h0000_00C0},  // R8
    {2'd2, 12'h514, 32'h0000_0030},  // R8
    {2'd1, 12'h510, 32'h0000_0011},  // R7
    {2'd2, 12'h514, 32'h0000_0020},  // R7
    {2'd2, 12'h510, 32'h0000_0011},  // R7
    {2'd1, 12'h420, 32'h0000_0003},  // alt select (R5)
    {2'd2, 12'h420, 32'h0000_0003},  // R5
    {2'd1, 12'h600, 32'hFFFF_FFFF},  // unmapped (R11)
    {2'd2, 12'h600, 32'h0000_0000},  // R11
    {2'd1, 12'h51C, 32'h0000_000F},  // den low nibble (R6)
    {2'd2, 12'h3FC, 32'h0000_000C},  // R6
    {2'd2, 12'h000, 32'h0000_0000}   // empty mask (R3)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe", {24'd0, pin_oe}, 32'd0);
    check("R1 out", {24'd0, pin_out}, 32'd0);
    check("R1 pulls", {16'd0, pin_pu, pin_pd}, 32'd0);
    bus_read(12'h400, rd); check("R1 dir", rd, 32'd0);
    bus_read(12'h3FC, rd); check("R1 data", rd, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][45:44] == 2'd1) bus_write(VEC[k][43:32], VEC[k][31:0]);
      else begin
        bus_read(VEC[k][43:32], rd);
        check($sformatf("vector %0d R2/R3/R5-R11", k), rd, VEC[k][31:0]);
      end
    end

    // R4, R5, R6: oe = dir(0F) & den(0F) & ~alt(03)
    check("R4 R5 oe", {24'd0, pin_oe}, 32'h0C);
    check("R2 pin_out", {24'd0, pin_out}, 32'hFC);
    check("R7 pin_pu", {24'd0, pin_pu}, 32'h11);
    check("R8 pin_pd", {24'd0, pin_pd}, 32'h20);

    // R10 synchronizer latency
    bus_write(12'h51C, 32'hFF);
    bus_write(12'h400, 32'h00);
    @(negedge clk);
    pin_in = 8'h3C;
    bus_addr = 12'h3FC; bus_re = 1'b1;
    #1 check("R10 no edge", bus_rdata, 32'hA5);
    @(negedge clk); #1 check("R10 one edge", bus_rdata, 32'hA5);
    @(negedge clk); #1 check("R10 two edges", bus_rdata, 32'h3C);
    bus_re = 1'b0;

    // R12 same-cycle write and read of direction
    @(negedge clk);
    bus_addr = 12'h400; bus_wdata = 32'h55; bus_we = 1'b1; bus_re = 1'b1;
    #1 check("R12 old value", bus_rdata, 32'h00);
    @(negedge clk);
    bus_we = 1'b0;
    #1 check("R12 new value", bus_rdata, 32'h55);
    bus_re = 1'b0;

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset oe", {24'd0, pin_oe}, 32'd0);
    bus_read(12'h51C, rd); check("R1 after reset den", rd, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule